// File: doc/BRIEF.md
# UART In-Band XON/XOFF Flow Controller

This block sits between a UART receiver, the transmit data queue and the transmit shift register, and handles software flow control. Each received byte is compared against four programmable characters: two "resume" characters and two "pause" characters. A received pause character holds the transmitter. A received resume character releases it. Recognised flow characters are removed from the received data stream. All other bytes are forwarded one cycle later.

On the transmit side, the block can insert a pause or resume character into the outgoing stream when requested. An inserted character goes ahead of any queued data byte and is offered at the next byte boundary of the shift register. Inserted characters are sent even while the transmitter is held.

A 4-bit configuration field controls both directions. Bits 3:2 set the transmit character set and bits 1:0 set the receive character set. In each 2-bit part, 00 disables flow handling, 10 selects set 1, 01 selects set 2, and 11 selects both sets sent or recognised as a back-to-back pair (set-1 character first). A separate option lets any received byte release the hold.

Top module: `uart_swflow_ctrl`

## Requirements
- R1: After reset, `stat_tx_held`, `stat_xoff_sent`, `irq_flow`, `rx_out_valid` and `tx_sr_valid` are 0 while no data is queued.
- R2: With receive part `cfg_flow[1:0]`=10, a received `chr_xoff1` sets `stat_tx_held` and a received `chr_xon1` clears it. Both take effect one cycle after the strobe, and neither byte is forwarded.
- R3: With receive part 01, only `chr_xon2`/`chr_xoff2` act. Set-1 characters are forwarded as ordinary data.
- R4: With receive part 11, a pause or resume counts only when the set-1 character is immediately followed by the matching set-2 character. Any set-1 flow character is consumed and (re)starts the pair. Any other byte breaks the pair and is forwarded, including a lone set-2 character.
- R5: With receive part 00, flow characters are forwarded as data and the hold state does not change.
- R6: A byte that is not consumed appears on `rx_out_byte` with `rx_out_valid` high for one cycle, one cycle after its `rx_valid` strobe.
- R7: With `cfg_xon_any`=1, any received byte other than a completed pause clears the hold. A non-flow byte received this way is still forwarded.
- R8: While `stat_tx_held` is 1, queued data is not offered: `tx_data_ready` is 0 and `tx_sr_valid` is 0 unless a flow character is pending.
- R9: A requested pause or resume character is offered on `tx_sr_byte` ahead of queued data. Transmit part 10 sends the set-1 character, 01 sends the set-2 character, and 11 sends set 1 then set 2 in consecutive accepted slots. Queued data bytes pass straight through when no flow character is pending.
- R10: With transmit part 00, insertion requests are ignored. Data continues to flow and `stat_xoff_sent` is unchanged.
- R11: `stat_xoff_sent` becomes 1 after the last character of a pause sequence is accepted (`tx_sr_valid` and `tx_sr_ready`). It becomes 0 after the last character of a resume sequence.
- R12: `irq_flow` pulses for one cycle, one cycle after each received byte that completes a pause or resume match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_flow | input | 4 | Bits 3:2 transmit set, bits 1:0 receive set (00 off, 10 set 1, 01 set 2, 11 both) |
| cfg_xon_any | input | 1 | Any received byte releases the hold |
| chr_xon1 | input | DATA_W | Resume character, set 1 |
| chr_xon2 | input | DATA_W | Resume character, set 2 |
| chr_xoff1 | input | DATA_W | Pause character, set 1 |
| chr_xoff2 | input | DATA_W | Pause character, set 2 |
| rx_valid | input | 1 | Received-byte strobe |
| rx_byte | input | DATA_W | Received byte |
| rx_out_valid | output | 1 | Forwarded byte valid |
| rx_out_byte | output | DATA_W | Forwarded received byte |
| tx_req_xoff | input | 1 | Request to send a pause sequence (wins over resume) |
| tx_req_xon | input | 1 | Request to send a resume sequence |
| tx_data_valid | input | 1 | Queued transmit byte available |
| tx_data | input | DATA_W | Queued transmit byte |
| tx_data_ready | output | 1 | Queued byte taken this cycle |
| tx_sr_ready | input | 1 | Shift register can accept a byte |
| tx_sr_valid | output | 1 | Byte offered to the shift register |
| tx_sr_byte | output | DATA_W | Byte offered to the shift register |
| stat_tx_held | output | 1 | Transmitter held by a received pause |
| stat_xoff_sent | output | 1 | A pause sequence was the last one sent |
| irq_flow | output | 1 | One-cycle pulse on a received flow match |

## Verification
Receive-side results are registered on the clock edge that samples the strobe. The bench drives each byte on a falling edge and reads the forwarded byte, hold flag and interrupt on the very next falling edge, when they are valid for exactly that one cycle.

Transmit-side offers are combinational from the pending state. A request pulsed before an edge therefore shows on `tx_sr_byte` at the following falling edge, and each accepted slot advances the sequence by one edge. The bench raises `tx_sr_ready` for one cycle per slot and checks the next offered byte and the sent-status flag one falling edge later.

// File: rtl/uart_swflow_pkg.sv
package uart_swflow_pkg;
   // Two-bit character-set selector; bit 1 enables set 1, bit 0 enables set 2.
   typedef enum logic [1:0] {
      SET_NONE = 2'b00,
      SET_TWO  = 2'b01,
      SET_ONE  = 2'b10,
      SET_BOTH = 2'b11
   } flow_set_e;

   localparam int unsigned CFG_W     = 4;
   localparam int unsigned NUM_SETS  = 2;
endpackage

// File: rtl/uart_swflow_rx_match.sv
module uart_swflow_rx_match
   import uart_swflow_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  flow_set_e         rx_set_i,
   input  logic              xon_any_i,
   input  logic [DATA_W-1:0] on1_i,
   input  logic [DATA_W-1:0] on2_i,
   input  logic [DATA_W-1:0] off1_i,
   input  logic [DATA_W-1:0] off2_i,
   input  logic              rx_valid_i,
   input  logic [DATA_W-1:0] rx_byte_i,
   output logic              out_valid_o,
   output logic [DATA_W-1:0] out_byte_o,
   output logic              held_o,
   output logic              irq_o
);
   logic [DATA_W-1:0] on_chr  [NUM_SETS];
   logic [DATA_W-1:0] off_chr [NUM_SETS];
   logic [NUM_SETS-1:0] hit_on, hit_off;

   assign on_chr[0]  = on1_i;
   assign on_chr[1]  = on2_i;
   assign off_chr[0] = off1_i;
   assign off_chr[1] = off2_i;

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_cmp
      assign hit_on[s]  = (rx_byte_i == on_chr[s]);
      assign hit_off[s] = (rx_byte_i == off_chr[s]);
   end

   logic arm_on, arm_off;
   logic arm_on_n, arm_off_n;
   logic got_on, got_off, eat;
   logic use1, use2;

   assign use1 = rx_set_i[1];
   assign use2 = rx_set_i[0];

   always_comb begin
      got_on    = 1'b0;
      got_off   = 1'b0;
      eat       = 1'b0;
      arm_on_n  = 1'b0;
      arm_off_n = 1'b0;
      if (use1 && use2) begin
         // Paired mode: set-1 character arms, matching set-2 character completes.
         if (arm_off && hit_off[1]) begin
            got_off = 1'b1;
            eat     = 1'b1;
         end else if (arm_on && hit_on[1]) begin
            got_on = 1'b1;
            eat    = 1'b1;
         end else if (hit_off[0]) begin
            arm_off_n = 1'b1;
            eat       = 1'b1;
         end else if (hit_on[0]) begin
            arm_on_n = 1'b1;
            eat      = 1'b1;
         end
      end else begin
         if ((use1 && hit_off[0]) || (use2 && hit_off[1])) begin
            got_off = 1'b1;
         end else if ((use1 && hit_on[0]) || (use2 && hit_on[1])) begin
            got_on = 1'b1;
         end
         eat = got_on | got_off;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arm_on      <= 1'b0;
         arm_off     <= 1'b0;
         out_valid_o <= 1'b0;
         out_byte_o  <= '0;
         held_o      <= 1'b0;
         irq_o       <= 1'b0;
      end else if (rx_valid_i) begin
         arm_on      <= arm_on_n;
         arm_off     <= arm_off_n;
         out_valid_o <= !eat;
         out_byte_o  <= rx_byte_i;
         irq_o       <= got_on | got_off;
         if (got_off) begin
            held_o <= 1'b1;
         end else if (got_on || xon_any_i) begin
            held_o <= 1'b0;
         end
      end else begin
         out_valid_o <= 1'b0;
         irq_o       <= 1'b0;
      end
   end
endmodule

// File: rtl/uart_swflow_tx_insert.sv
module uart_swflow_tx_insert
   import uart_swflow_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  flow_set_e         tx_set_i,
   input  logic [DATA_W-1:0] on1_i,
   input  logic [DATA_W-1:0] on2_i,
   input  logic [DATA_W-1:0] off1_i,
   input  logic [DATA_W-1:0] off2_i,
   input  logic              held_i,
   input  logic              req_off_i,
   input  logic              req_on_i,
   input  logic              data_valid_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              data_ready_o,
   input  logic              sr_ready_i,
   output logic              sr_valid_o,
   output logic [DATA_W-1:0] sr_byte_o,
   output logic              xoff_sent_o
);
   logic req_pend, req_kind;   // kind: 1 = pause, 0 = resume
   logic act, act_kind;        // second half of a paired sequence in flight
   logic ctl_pend, cur_kind, second, ctl_take, ctl_last;
   logic [DATA_W-1:0] ctl_chr;

   assign ctl_pend = act | req_pend;
   assign cur_kind = act ? act_kind : req_kind;
   assign second   = act | (tx_set_i == SET_TWO);
   assign ctl_chr  = cur_kind ? (second ? off2_i : off1_i)
                              : (second ? on2_i  : on1_i);
   assign ctl_take = sr_ready_i & ctl_pend;
   assign ctl_last = act | (tx_set_i != SET_BOTH);

   assign sr_valid_o   = ctl_pend | (data_valid_i & !held_i);
   assign sr_byte_o    = ctl_pend ? ctl_chr : data_i;
   assign data_ready_o = sr_ready_i & !ctl_pend & !held_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_pend    <= 1'b0;
         req_kind    <= 1'b0;
         act         <= 1'b0;
         act_kind    <= 1'b0;
         xoff_sent_o <= 1'b0;
      end else begin
         if (ctl_take) begin
            if (act) begin
               act <= 1'b0;
            end else begin
               req_pend <= 1'b0;
               if (tx_set_i == SET_BOTH) begin
                  act      <= 1'b1;
                  act_kind <= req_kind;
               end
            end
            if (ctl_last) begin
               xoff_sent_o <= cur_kind;
            end
         end
         if ((tx_set_i != SET_NONE) && (req_off_i || req_on_i)) begin
            req_pend <= 1'b1;
            req_kind <= req_off_i;
         end
      end
   end
endmodule

// File: rtl/uart_swflow_ctrl.sv
module uart_swflow_ctrl
   import uart_swflow_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CFG_W-1:0]  cfg_flow,
   input  logic              cfg_xon_any,
   input  logic [DATA_W-1:0] chr_xon1,
   input  logic [DATA_W-1:0] chr_xon2,
   input  logic [DATA_W-1:0] chr_xoff1,
   input  logic [DATA_W-1:0] chr_xoff2,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_byte,
   output logic              rx_out_valid,
   output logic [DATA_W-1:0] rx_out_byte,
   input  logic              tx_req_xoff,
   input  logic              tx_req_xon,
   input  logic              tx_data_valid,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_data_ready,
   input  logic              tx_sr_ready,
   output logic              tx_sr_valid,
   output logic [DATA_W-1:0] tx_sr_byte,
   output logic              stat_tx_held,
   output logic              stat_xoff_sent,
   output logic              irq_flow
);
   if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
      $error("uart_swflow_ctrl: DATA_W must be 5..9");
   end

   flow_set_e tx_set, rx_set;
   assign tx_set = flow_set_e'(cfg_flow[3:2]);
   assign rx_set = flow_set_e'(cfg_flow[1:0]);

   uart_swflow_rx_match #(.DATA_W(DATA_W)) u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_set_i    (rx_set),
      .xon_any_i   (cfg_xon_any),
      .on1_i       (chr_xon1),
      .on2_i       (chr_xon2),
      .off1_i      (chr_xoff1),
      .off2_i      (chr_xoff2),
      .rx_valid_i  (rx_valid),
      .rx_byte_i   (rx_byte),
      .out_valid_o (rx_out_valid),
      .out_byte_o  (rx_out_byte),
      .held_o      (stat_tx_held),
      .irq_o       (irq_flow)
   );

   uart_swflow_tx_insert #(.DATA_W(DATA_W)) u_tx (
      .clk          (clk),
      .rst_n        (rst_n),
      .tx_set_i     (tx_set),
      .on1_i        (chr_xon1),
      .on2_i        (chr_xon2),
      .off1_i       (chr_xoff1),
      .off2_i       (chr_xoff2),
      .held_i       (stat_tx_held),
      .req_off_i    (tx_req_xoff),
      .req_on_i     (tx_req_xon),
      .data_valid_i (tx_data_valid),
      .data_i       (tx_data),
      .data_ready_o (tx_data_ready),
      .sr_ready_i   (tx_sr_ready),
      .sr_valid_o   (tx_sr_valid),
      .sr_byte_o    (tx_sr_byte),
      .xoff_sent_o  (stat_xoff_sent)
   );
endmodule

// File: rtl/uart_swflow_ctrl_chk.sv
module uart_swflow_ctrl_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_valid,
   input logic              rx_out_valid,
   input logic              tx_data_valid,
   input logic [DATA_W-1:0] tx_data,
   input logic              tx_data_ready,
   input logic              tx_sr_ready,
   input logic              tx_sr_valid,
   input logic [DATA_W-1:0] tx_sr_byte,
   input logic              stat_tx_held,
   input logic              stat_xoff_sent,
   input logic              irq_flow
);
   assert_irq_from_rx_R12: assert property (@(posedge clk) disable iff (!rst_n)
      irq_flow |-> $past(rx_valid));

   assert_fwd_from_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_out_valid |-> $past(rx_valid));

   assert_hold_moves_on_rx_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(stat_tx_held) |-> $past(rx_valid));

   assert_no_data_when_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(stat_tx_held && tx_data_ready));

   assert_data_passthrough_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_data_ready && tx_data_valid) |-> (tx_sr_valid && tx_sr_byte == tx_data));

   assert_sent_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(stat_xoff_sent) |-> $past(tx_sr_valid && tx_sr_ready));
endmodule

bind uart_swflow_ctrl uart_swflow_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .rx_valid       (rx_valid),
   .rx_out_valid   (rx_out_valid),
   .tx_data_valid  (tx_data_valid),
   .tx_data        (tx_data),
   .tx_data_ready  (tx_data_ready),
   .tx_sr_ready    (tx_sr_ready),
   .tx_sr_valid    (tx_sr_valid),
   .tx_sr_byte     (tx_sr_byte),
   .stat_tx_held   (stat_tx_held),
   .stat_xoff_sent (stat_xoff_sent),
   .irq_flow       (irq_flow)
);

// File: tb/uart_swflow_ctrl_tb.sv
module uart_swflow_ctrl_tb;
   localparam int DW = 8;
   localparam logic [7:0] ON1 = 8'h11, OFF1 = 8'h13, ON2 = 8'h91, OFF2 = 8'h93;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [3:0] cfg_flow = '0;
   logic cfg_xon_any = 1'b0;
   logic rx_valid = 1'b0;
   logic [DW-1:0] rx_byte = '0;
   logic rx_out_valid;
   logic [DW-1:0] rx_out_byte;
   logic tx_req_xoff = 1'b0, tx_req_xon = 1'b0;
   logic tx_data_valid = 1'b0;
   logic [DW-1:0] tx_data = '0;
   logic tx_data_ready, tx_sr_valid;
   logic tx_sr_ready = 1'b0;
   logic [DW-1:0] tx_sr_byte;
   logic stat_tx_held, stat_xoff_sent, irq_flow;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   uart_swflow_ctrl #(.DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_flow(cfg_flow), .cfg_xon_any(cfg_xon_any),
      .chr_xon1(ON1), .chr_xon2(ON2), .chr_xoff1(OFF1), .chr_xoff2(OFF2),
      .rx_valid(rx_valid), .rx_byte(rx_byte),
      .rx_out_valid(rx_out_valid), .rx_out_byte(rx_out_byte),
      .tx_req_xoff(tx_req_xoff), .tx_req_xon(tx_req_xon),
      .tx_data_valid(tx_data_valid), .tx_data(tx_data), .tx_data_ready(tx_data_ready),
      .tx_sr_ready(tx_sr_ready), .tx_sr_valid(tx_sr_valid), .tx_sr_byte(tx_sr_byte),
      .stat_tx_held(stat_tx_held), .stat_xoff_sent(stat_xoff_sent), .irq_flow(irq_flow)
   );

   // Row: cfg[23:20] xany[19] byte[18:11] exp_valid[10] exp_byte[9:2] exp_held[1] exp_irq[0]
   localparam int NV = 17;
   localparam logic [23:0] VEC [NV] = '{
      {4'b0010, 1'b0, 8'h41, 1'b1, 8'h41, 1'b0, 1'b0},  // R6 data in set-1 mode
      {4'b0010, 1'b0, OFF1,  1'b0, OFF1,  1'b1, 1'b1},  // R2 pause set 1
      {4'b0010, 1'b0, 8'h42, 1'b1, 8'h42, 1'b1, 1'b0},  // R6 data while held
      {4'b0010, 1'b0, ON1,   1'b0, ON1,   1'b0, 1'b1},  // R2 resume set 1
      {4'b0001, 1'b0, OFF1,  1'b1, OFF1,  1'b0, 1'b0},  // R3 set-1 char is data
      {4'b0001, 1'b0, OFF2,  1'b0, OFF2,  1'b1, 1'b1},  // R3 pause set 2
      {4'b0001, 1'b0, ON2,   1'b0, ON2,   1'b0, 1'b1},  // R3 resume set 2
      {4'b0011, 1'b0, OFF1,  1'b0, OFF1,  1'b0, 1'b0},  // R4 first of pair
      {4'b0011, 1'b0, OFF2,  1'b0, OFF2,  1'b1, 1'b1},  // R4 pair complete
      {4'b0011, 1'b0, ON1,   1'b0, ON1,   1'b1, 1'b0},  // R4 arm resume
      {4'b0011, 1'b0, 8'h55, 1'b1, 8'h55, 1'b1, 1'b0},  // R4 pair broken
      {4'b0011, 1'b0, ON2,   1'b1, ON2,   1'b1, 1'b0},  // R4 lone second char
      {4'b0011, 1'b0, ON1,   1'b0, ON1,   1'b1, 1'b0},  // R4 re-arm
      {4'b0011, 1'b0, ON2,   1'b0, ON2,   1'b0, 1'b1},  // R4 resume pair
      {4'b0000, 1'b0, OFF1,  1'b1, OFF1,  1'b0, 1'b0},  // R5 disabled
      {4'b0010, 1'b1, OFF1,  1'b0, OFF1,  1'b1, 1'b1},  // R7 set up hold
      {4'b0010, 1'b1, 8'h20, 1'b1, 8'h20, 1'b0, 1'b0}   // R7 any byte releases
   };

   function automatic string row_tag(input int i);
      if (i == 0 || i == 2) return "R6";
      if (i <= 3) return "R2";
      if (i <= 6) return "R3";
      if (i <= 13) return "R4";
      if (i == 14) return "R5";
      return "R7";
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rx_send(input logic [7:0] b);
      rx_valid = 1'b1;
      rx_byte  = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic pulse_req(input logic off);
      tx_req_xoff = off;
      tx_req_xon  = !off;
      @(negedge clk);
      tx_req_xoff = 1'b0;
      tx_req_xon  = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 held", stat_tx_held, 0);
      chk("R1 xoff_sent", stat_xoff_sent, 0);
      chk("R1 irq", irq_flow, 0);
      chk("R1 rx_out_valid", rx_out_valid, 0);
      chk("R1 tx_sr_valid", tx_sr_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         cfg_flow    = VEC[i][23:20];
         cfg_xon_any = VEC[i][19];
         rx_send(VEC[i][18:11]);
         chk(row_tag(i), rx_out_valid, VEC[i][10]);
         if (VEC[i][10]) chk(row_tag(i), rx_out_byte, VEC[i][9:2]);
         chk(row_tag(i), stat_tx_held, VEC[i][1]);
         chk({row_tag(i), "/R12 irq"}, irq_flow, VEC[i][0]);
         @(negedge clk);
         chk("R12 single pulse", irq_flow, 0);
      end
      cfg_xon_any = 1'b0;

      // R8: hold gates queued data
      cfg_flow = 4'b0010;
      tx_data_valid = 1'b1;
      tx_data = 8'h61;
      tx_sr_ready = 1'b1;
      rx_send(OFF1);
      chk("R8 sr_valid held", tx_sr_valid, 0);
      chk("R8 data_ready held", tx_data_ready, 0);
      rx_send(ON1);
      chk("R8 sr_valid released", tx_sr_valid, 1);
      chk("R9 data passthrough", tx_sr_byte, 8'h61);
      chk("R8 data_ready released", tx_data_ready, 1);

      // R9/R11: transmit set 1 pause ahead of data
      tx_sr_ready = 1'b0;
      cfg_flow = 4'b1010;
      pulse_req(1'b1);
      chk("R9 set1 pause byte", tx_sr_byte, OFF1);
      chk("R9 data waits", tx_data_ready, 0);
      tx_sr_ready = 1'b1;
      @(negedge clk);
      tx_sr_ready = 1'b0;
      chk("R11 xoff sent", stat_xoff_sent, 1);
      chk("R9 data resumes", tx_sr_byte, 8'h61);

      // R9/R11: transmit both sets, resume pair
      cfg_flow = 4'b1110;
      pulse_req(1'b0);
      chk("R9 pair first", tx_sr_byte, ON1);
      tx_sr_ready = 1'b1;
      @(negedge clk);
      chk("R9 pair second", tx_sr_byte, ON2);
      chk("R11 not yet cleared", stat_xoff_sent, 1);
      @(negedge clk);
      tx_sr_ready = 1'b0;
      chk("R11 cleared after resume", stat_xoff_sent, 0);
      chk("R9 data after pair", tx_sr_byte, 8'h61);

      // R9: transmit set 2 pause
      cfg_flow = 4'b0110;
      pulse_req(1'b1);
      chk("R9 set2 pause byte", tx_sr_byte, OFF2);
      tx_sr_ready = 1'b1;
      @(negedge clk);
      tx_sr_ready = 1'b0;
      chk("R11 set after set2 pause", stat_xoff_sent, 1);

      // R10: transmit part off, requests ignored
      cfg_flow = 4'b0010;
      pulse_req(1'b0);
      chk("R10 no insert", tx_sr_byte, 8'h61);
      tx_sr_ready = 1'b1;
      @(negedge clk);
      tx_sr_ready = 1'b0;
      chk("R10 status unchanged", stat_xoff_sent, 1);
      chk("R10 still no insert", tx_sr_byte, 8'h61);

      // R9/R8: flow character goes out while held, data stays gated
      cfg_flow = 4'b1010;
      rx_send(OFF1);
      pulse_req(1'b0);
      chk("R9 insert while held", tx_sr_valid, 1);
      chk("R9 insert byte while held", tx_sr_byte, ON1);
      tx_sr_ready = 1'b1;
      @(negedge clk);
      chk("R11 cleared while held", stat_xoff_sent, 0);
      chk("R8 held after insert", tx_sr_valid, 0);
      chk("R8 no data_ready", tx_data_ready, 0);
      tx_sr_ready = 1'b0;
      rx_send(ON1);
      chk("R2 released", stat_tx_held, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule